// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a free-running module clock into a one-cycle oversampling strobe at sixteen times the serial bit rate, plus a second one-cycle strobe once per bit period. The division ratio is a fixed-point number with a 16-bit whole part and a 6-bit fraction counted in 1/64 steps. When the fraction is non-zero, the block alternates between periods of N and N+1 clocks, so that the average period over many strobes equals N + F/64.

Software loads the two halves of the ratio through separate write strobes. A fraction write only goes into a holding register. The next whole-part write applies both halves together and restarts the phase, so a half-updated ratio never reaches the strobe. A whole part of zero stops both strobes.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the whole part is zero, so `tick16_o` and `bit_tick_o` stay 0 until a whole-part write.
- R2: With whole part N ≥ 1 and fraction 0, `tick16_o` is high for one cycle in every N cycles. With N = 1 it is high on every cycle.
- R3: With whole part N and fraction F, call the clock edge that samples `int_wr_i` edge 0. The k-th strobe (k = 1, 2, …) is high in the cycle after edge k·N + floor((k−1)·F/64) − 1. Each gap between strobes is therefore N or N+1 cycles.
- R4: A write on `frac_wr_i` alone does not change strobe timing. The written value is used only from the next `int_wr_i`. If both strobes arrive in the same cycle, the new fraction is used.
- R5: A write on `int_wr_i` restarts the phase. The first strobe comes N cycles after the write edge, whatever the earlier state was. Changes on `int_val_i` without `int_wr_i` are ignored.
- R6: A whole part of 0 holds both `tick16_o` and `bit_tick_o` low for as long as it stays loaded.
- R7: `bit_tick_o` is high only together with `tick16_o`, on every 16th strobe counted from the last whole-part write (strobes 16, 32, …).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_wr_i | input | 1 | Whole-part write strobe; applies the new ratio |
| int_val_i | input | 16 | Whole part of the divisor |
| frac_wr_i | input | 1 | Fraction write strobe (held until the next whole-part write) |
| frac_val_i | input | 6 | Fraction of the divisor in 1/64 units |
| tick16_o | output | 1 | One-cycle strobe at sixteen times the bit rate |
| bit_tick_o | output | 1 | One-cycle strobe once per bit period |

## Verification
A wrong phase accumulator shows up as a strobe that is one cycle early or late. This first appears at the first carry, which comes within 64 strobes of a whole-part write for any non-zero fraction. A wrong period counter or a lost commit moves the very first strobe away from N cycles after the write edge. A bad bit-period count shows up by strobe 16 at the latest. The bench compares both outputs on every cycle against the closed-form strobe times in R3, so any of these faults shows up at the exact cycle where it first occurs.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
    localparam int DEF_INT_W   = 16;
    localparam int DEF_FRAC_W  = 6;
    localparam int DEF_OVS_LOG = 4;
endpackage

// File: rtl/frac_baud_acc.sv
module frac_baud_acc #(
    parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W
) (
    input  logic [FRAC_W-1:0] acc_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [FRAC_W-1:0] sum_o,
    output logic              carry_o
);
    logic [FRAC_W:0] wide;

    always_comb begin
        wide    = {1'b0, acc_i} + {1'b0, frac_i};
        sum_o   = wide[FRAC_W-1:0];
        carry_o = wide[FRAC_W];
    end
endmodule

// File: rtl/frac_baud_sub.sv
module frac_baud_sub #(
    parameter int OVS_LOG = frac_baud_pkg::DEF_OVS_LOG
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic adv_i,
    output logic bit_o
);
    logic [OVS_LOG-1:0] sub_d, sub_q;

    always_comb begin
        sub_d = sub_q;
        if (clr_i)      sub_d = '0;
        else if (adv_i) sub_d = sub_q + 1'b1;
        bit_o = adv_i && (sub_q == {OVS_LOG{1'b1}});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sub_q <= '0;
        else         sub_q <= sub_d;
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int INT_W   = frac_baud_pkg::DEF_INT_W,
    parameter int FRAC_W  = frac_baud_pkg::DEF_FRAC_W,
    parameter int OVS_LOG = frac_baud_pkg::DEF_OVS_LOG
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              int_wr_i,
    input  logic [INT_W-1:0]  int_val_i,
    input  logic              frac_wr_i,
    input  logic [FRAC_W-1:0] frac_val_i,
    output logic              tick16_o,
    output logic              bit_tick_o
);
    localparam int PW = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
        logic [FRAC_W-1:0] stage;
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              extra;
    } state_t;

    state_t st_d, st_q;

    logic [FRAC_W-1:0] acc_sum;
    logic              acc_carry;
    logic [PW-1:0]     period_m1;
    logic              hit;

    frac_baud_acc #(.FRAC_W(FRAC_W)) u_acc (
        .acc_i   (st_q.acc),
        .frac_i  (st_q.frac),
        .sum_o   (acc_sum),
        .carry_o (acc_carry)
    );

    frac_baud_sub #(.OVS_LOG(OVS_LOG)) u_sub (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (int_wr_i),
        .adv_i  (hit),
        .bit_o  (bit_tick_o)
    );

    always_comb begin
        period_m1 = {1'b0, st_q.whole} + {{(PW-1){1'b0}}, st_q.extra} - {{(PW-1){1'b0}}, 1'b1};
        hit       = (st_q.whole != '0) && ({1'b0, st_q.cnt} == period_m1);

        st_d       = st_q;
        st_d.stage = frac_wr_i ? frac_val_i : st_q.stage;

        if (int_wr_i) begin
            st_d.whole = int_val_i;
            st_d.frac  = st_d.stage;
            st_d.cnt   = '0;
            st_d.acc   = '0;
            st_d.extra = 1'b0;
        end else if (st_q.whole == '0) begin
            st_d.cnt   = '0;
        end else if (hit) begin
            st_d.cnt   = '0;
            st_d.acc   = acc_sum;
            st_d.extra = acc_carry;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick16_o = hit;
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
    parameter int INT_W   = 16,
    parameter int OVS_LOG = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             int_wr_i,
    input logic [INT_W-1:0] int_val_i,
    input logic             tick16_o,
    input logic             bit_tick_o
);
    logic [INT_W-1:0]   n_q;
    logic [INT_W+1:0]   gap_q;
    logic               seen_q;
    logic [OVS_LOG-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            n_q <= '0; gap_q <= '0; seen_q <= 1'b0; cnt_q <= '0;
        end else if (int_wr_i) begin
            n_q <= int_val_i; gap_q <= '0; seen_q <= 1'b0; cnt_q <= '0;
        end else begin
            if (tick16_o) begin
                gap_q  <= 1;
                seen_q <= 1'b1;
                cnt_q  <= cnt_q + 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R7
    assert_bit_in_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |-> tick16_o);
    // R7
    assert_bit_every16_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick16_o && !int_wr_i) |-> (bit_tick_o == (cnt_q == {OVS_LOG{1'b1}})));
    // R1, R6
    assert_zero_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (n_q == '0 && !int_wr_i) |-> (!tick16_o && !bit_tick_o));
    // R3
    assert_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick16_o && seen_q && !int_wr_i) |->
        (gap_q == {2'b00, n_q} || gap_q == {2'b00, n_q} + 1'b1));
    // R5
    assert_first_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick16_o && !seen_q && !int_wr_i) |-> (gap_q == {2'b00, n_q} - 1'b1));
    // R5
    assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_wr_i && int_val_i > 1) |=> !tick16_o);
endmodule

bind frac_baud_gen frac_baud_chk #(.INT_W(INT_W), .OVS_LOG(OVS_LOG)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_wr_i   (int_wr_i),
    .int_val_i  (int_val_i),
    .tick16_o   (tick16_o),
    .bit_tick_o (bit_tick_o)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        int_wr_i = 1'b0;
    logic [15:0] int_val_i = '0;
    logic        frac_wr_i = 1'b0;
    logic [5:0]  frac_val_i = '0;
    logic        tick16_o, bit_tick_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    frac_baud_gen uut (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .int_wr_i(int_wr_i), .int_val_i(int_val_i),
        .frac_wr_i(frac_wr_i), .frac_val_i(frac_val_i),
        .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
    );

    task automatic cmp(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // k-th strobe offset (0 = first sample after commit edge)
    function automatic longint t_of(input longint k, input longint n, input longint f);
        return k * n + ((k - 1) * f) / 64 - 1;
    endfunction

    task automatic commit(input int n, input int f, input bit wr_frac);
        @(negedge clk_i);
        if (wr_frac) begin
            frac_wr_i = 1'b1; frac_val_i = f[5:0];
            @(negedge clk_i);
            frac_wr_i = 1'b0;
        end
        int_wr_i = 1'b1; int_val_i = n[15:0];
        @(negedge clk_i);
        int_wr_i = 1'b0;
        int_val_i = 16'hBEEF;
    endtask

    // At offset 0 on entry; checks cycles and disturbs with ignored writes
    task automatic follow(input string req, input int n, input int f, input int cycles,
                          input bit disturb);
        longint k = 1;
        for (int o = 0; o < cycles; o++) begin
            bit exp_t;
            bit exp_b;
            exp_t = (n != 0) && (t_of(k, n, f) == o);
            exp_b = exp_t && (k % 16 == 0);
            cmp(req, tick16_o, exp_t);
            cmp({req, " R7"}, bit_tick_o, exp_b);
            if (exp_t) k++;
            if (disturb && o == 7) begin
                frac_wr_i = 1'b1; frac_val_i = 6'd41;  // R4: held only
                int_val_i = 16'd3;                      // R5: ignored without strobe
            end else begin
                frac_wr_i = 1'b0;
            end
            @(negedge clk_i);
        end
    endtask

    initial begin
        int nlist[5] = '{1, 2, 3, 5, 7};
        int flist[6] = '{0, 1, 17, 32, 47, 63};
        repeat (3) @(negedge clk_i);
        // R1: reset state
        cmp("R1", tick16_o, 1'b0);
        cmp("R1", bit_tick_o, 1'b0);
        rst_ni = 1'b1;
        follow("R1", 0, 0, 40, 1'b0);

        // R2 / R3 sweep
        foreach (nlist[i]) begin
            foreach (flist[j]) begin
                commit(nlist[i], flist[j], 1'b1);
                follow(flist[j] == 0 ? "R2" : "R3", nlist[i], flist[j], 70 * nlist[i] + 80, 1'b0);
            end
        end

        // R4: fraction write alone does not alter timing
        commit(4, 9, 1'b1);
        follow("R4", 4, 9, 600, 1'b1);
        // the held value 41 now takes effect with the next whole-part write
        commit(3, 0, 1'b0);
        follow("R4", 3, 41, 400, 1'b0);
        // R4: both strobes in the same cycle use the new fraction
        @(negedge clk_i);
        frac_wr_i = 1'b1; frac_val_i = 6'd25; int_wr_i = 1'b1; int_val_i = 16'd2;
        @(negedge clk_i);
        frac_wr_i = 1'b0; int_wr_i = 1'b0; int_val_i = 16'h1234;
        follow("R4", 2, 25, 300, 1'b0);

        // R5: restart in the middle of a period
        commit(9, 5, 1'b1);
        follow("R5", 9, 5, 13, 1'b0);
        commit(6, 5, 1'b0);
        follow("R5", 6, 5, 500, 1'b1);

        // R6: zero whole part stops strobes
        commit(0, 20, 1'b1);
        follow("R6", 0, 20, 200, 1'b1);

        // large whole part
        commit(300, 33, 1'b1);
        follow("R3", 300, 33, 10000, 1'b0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk_i);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule